// File: doc/BRIEF.md
# Compensated Approximate Squarer

This unit squares an N-bit unsigned operand without a multiplier and without any adder. Each output bit is a small AND/OR expression of the operand bits. The method first places every operand bit at the even output position twice its index. It then folds in the two nearest families of cross products exactly. Those additions never produce a carry that lands on a bit that is already set, so they reduce to gates. Every cross product that lies further apart is merged into its output bit with an OR instead of being added. The result is therefore never larger than the true square, and it is deliberately inexact for some operands.

The block is purely combinational and is meant to sit in paths where a fast estimate of a square is enough. Typical uses are distance metrics, error-correction branch metrics and codebook searches. At a width of four bits an optional fix-up stage recognises the only two operands that square wrongly, 13 and 15. For those two it drives their exact squares, so the 4-bit instance becomes exact.

Top module: `csq_unit`

## Requirements
- R1: An operand of 0 yields 0 and an operand of 1 yields 1.
- R2: Output bit 1 is always 0 and output bit 0 always equals operand bit 0.
- R3: The most significant output bit equals the AND of the two most significant operand bits.
- R4: With the fix-up absent, the output equals the following value: the sum over i of a_i·4^i, plus a_i·a_(i-1)·4^i for i ≥ 1, plus a_i·a_(i-2)·2^(2i-1) for i ≥ 2. That sum is then bitwise ORed with a_i·a_j placed at bit i+j+1 for every pair with i−j ≥ 3.
- R5: The output never exceeds the exact square of the operand.
- R6: At N = 4 without fix-up, every operand squares exactly except 13, which gives 153, and 15, which gives 209.
- R7: At N = 4 without fix-up, the largest relative error over all 16 operands lies between 9.4 % and 9.5 %. The mean relative error over all 16 operands, counting 0 as error-free, lies between 1.0 % and 1.1 %.
- R8: With CORRECT = 1 and N = 4, operand 13 gives 169, operand 15 gives 225, and every operand squares exactly.
- R9: CORRECT = 1 at any width other than 4 has no effect: the output still follows R4.
- R10: The output follows an operand change with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Unsigned operand to be squared |
| r | output | 2*N | Approximate (or, with fix-up at N = 4, exact) square |

## Verification
The hardest region to reach is the set of operands where cross products far apart in index collide on an output bit that the exact square would have carried out of. The OR merge then loses value there. At 4 bits this happens for just two operands. At wider widths it needs several high and low bits set together. The stimulus therefore sweeps every operand of a 10-bit instance against an arithmetic model of the compensation rule. It also walks a full 16-entry expected-value table for the 4-bit instance. Both passes collect the error statistics that bound the approximation.

// File: rtl/csq_pkg.sv
package csq_pkg;

    // Width at which the fix-up stage is defined.
    localparam int unsigned FIX_WIDTH = 4;
    localparam int unsigned FIX_RW    = 2 * FIX_WIDTH;

    // Operands whose compensated square is wrong at the fix-up width.
    localparam logic [FIX_WIDTH-1:0] FIX_OP_LO = 4'd13;
    localparam logic [FIX_WIDTH-1:0] FIX_OP_HI = 4'd15;
    localparam logic [FIX_RW-1:0]    FIX_SQ_LO = 8'd169;
    localparam logic [FIX_RW-1:0]    FIX_SQ_HI = 8'd225;

    // Result of the fix-up lookup: hit flag plus replacement square.
    typedef struct packed {
        logic                 hit;
        logic [FIX_RW-1:0]    square;
    } fix_t;

    function automatic fix_t fix_lookup(input logic [FIX_WIDTH-1:0] op);
        fix_t f;
        f.hit    = 1'b0;
        f.square = '0;
        if (op == FIX_OP_LO) begin
            f.hit    = 1'b1;
            f.square = FIX_SQ_LO;
        end else if (op == FIX_OP_HI) begin
            f.hit    = 1'b1;
            f.square = FIX_SQ_HI;
        end
        return f;
    endfunction

endpackage

// File: rtl/csq_pair_stage.sv
// Pure terms plus exactly-added nearest and next-nearest cross products.
// Every carry produced by those additions lands on a bit that is known to
// be clear, so each output bit reduces to a small AND/OR/XOR expression.
module csq_pair_stage #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]   a,
    output logic [2*N-1:0] base_r
);
    localparam int unsigned RW = 2 * N;

    logic [RW-1:0] bits;

    assign bits[0] = a[0];
    assign bits[1] = 1'b0;

    generate
        for (genvar i = 1; i < N; i++) begin : g_pos
            // Even bit 2i: a_i alone, or a_i with the carry of the
            // next-nearest fold (needs a_(i-1) and a_(i-2)).
            if (i >= 2) begin : g_even_carry
                assign bits[2*i] = a[i] & (~a[i-1] | a[i-2]);
            end else begin : g_even_plain
                assign bits[2*i] = a[i] & ~a[i-1];
            end
            // Odd bit 2i+1: nearest pair, modified by the next-nearest
            // term of the neighbour above when one exists.
            if (i + 1 < N) begin : g_odd_mixed
                assign bits[2*i+1] = (a[i+1] ^ a[i]) & a[i-1];
            end else begin : g_odd_top
                assign bits[2*i+1] = a[i] & a[i-1];
            end
        end
    endgenerate

    assign base_r = bits;
endmodule

// File: rtl/csq_fold.sv
// Distant cross products a_i*a_j (i-j >= 3) are merged by OR at bit i+j+1.
module csq_fold #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]   a,
    output logic [2*N-1:0] fold_r
);
    localparam int unsigned RW   = 2 * N;
    localparam int unsigned GAP  = 3;

    always_comb begin
        fold_r = '0;
        for (int i = GAP; i < N; i++) begin
            for (int j = 0; j + GAP <= i; j++) begin
                fold_r[i+j+1] = fold_r[i+j+1] | (a[i] & a[j]);
            end
        end
    end
endmodule

// File: rtl/csq_fix.sv
// Replaces the two known-wrong 4-bit results with the exact squares.
module csq_fix
    import csq_pkg::*;
(
    input  logic [FIX_WIDTH-1:0] op,
    input  logic [FIX_RW-1:0]    approx,
    output logic [FIX_RW-1:0]    fixed
);
    fix_t look;

    always_comb begin
        look  = fix_lookup(op);
        fixed = look.hit ? look.square : approx;
    end
endmodule

// File: rtl/csq_unit.sv
module csq_unit
    import csq_pkg::*;
#(
    parameter int unsigned N       = 4,
    parameter bit          CORRECT = 1'b0
) (
    input  logic [N-1:0]   a,
    output logic [2*N-1:0] r
);
    localparam int unsigned RW      = 2 * N;
    localparam bit          USE_FIX = CORRECT && (N == FIX_WIDTH);

    logic [RW-1:0] base_r;
    logic [RW-1:0] fold_r;
    logic [RW-1:0] approx_r;

    csq_pair_stage #(.N(N)) u_pair (
        .a      (a),
        .base_r (base_r)
    );

    csq_fold #(.N(N)) u_fold (
        .a      (a),
        .fold_r (fold_r)
    );

    assign approx_r = base_r | fold_r;

    generate
        if (USE_FIX) begin : g_fix
            csq_fix u_fix (
                .op     (a),
                .approx (approx_r),
                .fixed  (r)
            );
        end else begin : g_nofix
            assign r = approx_r;
        end
    endgenerate
endmodule

// File: rtl/csq_unit_chk.sv
module csq_unit_chk #(
    parameter int unsigned N       = 4,
    parameter bit          CORRECT = 1'b0
) (
    input logic [N-1:0]   a,
    input logic [2*N-1:0] r,
    input logic [2*N-1:0] approx_r
);
    localparam int unsigned RW = 2 * N;

    logic [RW-1:0] exact_sq;
    assign exact_sq = {{N{1'b0}}, a} * {{N{1'b0}}, a};

    always_comb begin
        if (a == '0) begin
            assert_zero_R1: assert (r == '0)
                else $error("R1: zero operand gave %0d", r);
        end
        assert_low_bits_R2: assert (r[1] == 1'b0 && r[0] == a[0])
            else $error("R2: low bits %b for operand %0d", r[1:0], a);
        assert_top_bit_R3: assert (r[RW-1] == (a[N-1] & a[N-2]))
            else $error("R3: top bit wrong for operand %0d", a);
        assert_bounded_R5: assert (r <= exact_sq)
            else $error("R5: %0d exceeds %0d", r, exact_sq);
        if (CORRECT && N == 4) begin
            assert_exact_R8: assert (r == exact_sq)
                else $error("R8: %0d is not %0d", r, exact_sq);
        end else begin
            assert_passthru_R9: assert (r == approx_r)
                else $error("R9: output differs from compensated value");
        end
    end
endmodule

bind csq_unit csq_unit_chk #(.N(N), .CORRECT(CORRECT)) u_chk (
    .a        (a),
    .r        (r),
    .approx_r (approx_r)
);

// File: tb/test_csq_unit.sv
module test_csq_unit;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0]  a4;   logic [7:0]  r4;
    logic [3:0]  a4c;  logic [7:0]  r4c;
    logic [9:0]  a10;  logic [19:0] r10;
    logic [4:0]  a5c;  logic [9:0]  r5c;

    csq_unit #(.N(4),  .CORRECT(1'b0)) i_csq_unit (.a(a4),  .r(r4));
    csq_unit #(.N(4),  .CORRECT(1'b1)) u_fix4     (.a(a4c), .r(r4c));
    csq_unit #(.N(10), .CORRECT(1'b0)) u_w10      (.a(a10), .r(r10));
    csq_unit #(.N(5),  .CORRECT(1'b1)) u_w5c      (.a(a5c), .r(r5c));

    // Expected 4-bit uncorrected results, indexed by operand (R6).
    localparam logic [7:0] VEC4 [16] = '{
        8'd0,   8'd1,   8'd4,   8'd9,   8'd16,  8'd25,  8'd36,  8'd49,
        8'd64,  8'd81,  8'd100, 8'd121, 8'd144, 8'd153, 8'd196, 8'd209
    };

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Arithmetic model of the compensation rule (R4).
    function automatic longint model(input int n, input longint v);
        longint s = 0;
        longint o = 0;
        for (int i = 0; i < n; i++) begin
            if (v[i]) s += longint'(1) << (2 * i);
            if (i >= 1 && v[i] && v[i-1]) s += longint'(1) << (2 * i);
            if (i >= 2 && v[i] && v[i-2]) s += longint'(1) << (2 * i - 1);
            for (int j = 0; j + 3 <= i; j++)
                if (v[i] && v[j]) o |= longint'(1) << (i + j + 1);
        end
        return s | o;
    endfunction

    initial begin
        real max_e;
        real sum_e;
        real e;
        a4 = '0; a4c = '0; a10 = '0; a5c = '0;
        @(negedge clk);
        // Initial state with zero operand (R1)
        check(r4 == 8'd0, "R1", r4, 0);
        check(r10 == 20'd0, "R1", r10, 0);

        // Table walk on the 4-bit instance (R6, R7)
        max_e = 0.0; sum_e = 0.0;
        for (int v = 0; v < 16; v++) begin
            @(posedge clk); a4 = v[3:0];
            @(negedge clk);
            check(r4 == VEC4[v], "R6", r4, VEC4[v]);
            if (v > 0) begin
                e = real'(v * v - int'(r4)) / real'(v * v) * 100.0;
                sum_e += e;
                if (e > max_e) max_e = e;
            end
        end
        check(max_e > 9.4 && max_e < 9.5, "R7", longint'(max_e * 100.0), 947);
        check(sum_e / 16.0 > 1.0 && sum_e / 16.0 < 1.1, "R7",
              longint'(sum_e / 16.0 * 100.0), 104);

        // Operand 1 (R1) and low/top bit rules on 4 bits (R2, R3)
        @(posedge clk); a4 = 4'd1;
        @(negedge clk); check(r4 == 8'd1, "R1", r4, 1);
        @(posedge clk); a4 = 4'd11;
        @(negedge clk);
        check(r4[1] == 1'b0 && r4[0] == 1'b1, "R2", r4[1:0], 1);
        check(r4[7] == 1'b0, "R3", r4[7], 0);

        // Corrected 4-bit instance is exact everywhere (R8)
        for (int v = 0; v < 16; v++) begin
            @(posedge clk); a4c = v[3:0];
            @(negedge clk);
            check(int'(r4c) == v * v, "R8", r4c, v * v);
        end

        // Fix-up has no effect at 5 bits (R9)
        for (int v = 0; v < 32; v++) begin
            @(posedge clk); a5c = v[4:0];
            @(negedge clk);
            check(longint'(r5c) == model(5, v), "R9", r5c, model(5, v));
        end

        // Full 10-bit sweep against the model and the bound (R4, R5, R2, R3)
        max_e = 0.0; sum_e = 0.0;
        for (int v = 0; v < 1024; v++) begin
            @(posedge clk); a10 = v[9:0];
            @(negedge clk);
            check(longint'(r10) == model(10, v), "R4", r10, model(10, v));
            check(longint'(r10) <= longint'(v) * v, "R5", r10, longint'(v) * v);
            check(r10[1] == 1'b0 && r10[0] == a10[0], "R2", r10[1:0], a10[0]);
            check(r10[19] == (a10[9] & a10[8]), "R3", r10[19], a10[9] & a10[8]);
            if (v > 0) begin
                e = real'(longint'(v) * v - longint'(r10)) / real'(longint'(v) * v) * 100.0;
                sum_e += e;
                if (e > max_e) max_e = e;
            end
        end
        $display("10-bit max error %0.2f %%, mean error %0.2f %%", max_e, sum_e / 1024.0);

        // Output follows operand with no clock edge (R10)
        @(negedge clk);
        a4 = 4'd13; #2;
        check(r4 == 8'd153, "R10", r4, 153);
        a4 = 4'd7;  #2;
        check(r4 == 8'd49, "R10", r4, 49);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule